// File: doc/BRIEF.md
# Evenly Spaced Temporal Decimator

This block decides, for each incoming video unit, whether that unit is captured or dropped. A unit is either a single field or a whole frame, chosen by a mode input. The block works over a repeating sequence of units. The sequence length comes from a standard select: 60 units or 50 units. Within each sequence the block drops exactly the number of units held in a skip-count input, and it spaces the drops as evenly as it can. It never takes them in a burst. A capture system uses the capture-enable output to gate its active-video signal, so a lower, steady frame rate keeps uniform spacing in time.

The decision comes from an accumulator. At every unit it adds the skip count and compares the sum with the sequence length. A unit is dropped whenever the sum reaches or passes the length, and the length is then taken back off the sum. A new skip count is taken only at the first unit of a sequence, so each sequence uses one count only. A change of standard restarts the sequence.

Top module: `tdec_top`

## Requirements
- R1: While `rst` is high and after it falls, `capture_en` is 1 and the accumulator and the sequence position are zero.
- R2: In field mode (`frame_mode`=0), each `unit_start` pulse is one unit, whatever the value of `first_fld`. The decision appears on `capture_en` in the cycle after the pulse and holds until the next unit.
- R3: With a skip count N (1..L), any sequence of L units that starts at a sequence boundary has exactly N units with `capture_en`=0.
- R4: Skips are spread evenly. For N ≤ L/2 no two units in a row are skipped, and no run of captured units is longer than (L-1)/N, rounded down. For N = L/2 the units alternate, and the first unit is captured.
- R5: A latched skip count of 0 disables decimation. Every unit is captured, and the accumulator and position stay at zero, so a count loaded later is taken at the very next unit.
- R6: A skip count of L or above is treated as L, so every unit is skipped.
- R7: `std_sel`=0 selects a 60-unit sequence and `std_sel`=1 selects a 50-unit sequence.
- R8: In frame mode (`frame_mode`=1), only a `unit_start` pulse with `first_fld`=1 advances the sequence. A pulse with `first_fld`=0 leaves `capture_en` unchanged, so both fields of a frame share one decision.
- R9: The block samples `skip_cnt` only at the first unit of a sequence. A change made in the middle of a sequence takes effect at the next boundary.
- R10: A change of `std_sel` clears the accumulator and the position. The next unit starts a new sequence and takes the current `skip_cnt`.
- R11: Outside a standard-change cycle, the accumulator and the position both stay below the sequence length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_start | input | 1 | One-cycle pulse at the start of each field |
| first_fld | input | 1 | High when the pulsed field is the first field of a frame |
| frame_mode | input | 1 | 0 = decimate fields, 1 = decimate frames |
| std_sel | input | 1 | 0 = 60-unit sequence, 1 = 50-unit sequence |
| skip_cnt | input | CNT_W | Units to drop per sequence (0 disables) |
| capture_en | output | 1 | 1 = capture the current unit, 0 = skip it |

## Verification
The assertions assume that `unit_start` is a one-cycle pulse separated by idle cycles. They also assume that `std_sel` changes only between pulses, and that `skip_cnt` is stable during the cycle of a pulse. The bench drives every input on the falling edge. Each unit pulse lasts one cycle and is followed by an idle cycle. Every change of standard or skip count is made on its own cycle, with no pulse in that cycle. So the only behaviour the bench exercises is the behaviour the requirements define.

// File: rtl/tdec_pkg.sv
package tdec_pkg;

    localparam int SEQ_LEN_SIXTY = 60;
    localparam int SEQ_LEN_FIFTY = 50;

    typedef enum logic {
        STD_SIXTY = 1'b0,
        STD_FIFTY = 1'b1
    } std_kind_e;

    typedef struct packed {
        logic advance;
        logic repeat_prev;
    } unit_event_t;

    function automatic int unsigned len_of(input std_kind_e kind,
                                          input int unsigned len_a,
                                          input int unsigned len_b);
        return (kind == STD_FIFTY) ? len_b : len_a;
    endfunction

endpackage

// File: rtl/tdec_unit_gate.sv
module tdec_unit_gate
    import tdec_pkg::*;
(
    input  logic        unit_start,
    input  logic        first_fld,
    input  logic        frame_mode,
    output unit_event_t ev
);
    always_comb begin
        ev.advance     = unit_start && (!frame_mode || first_fld);
        ev.repeat_prev = unit_start && frame_mode && !first_fld;
    end
endmodule

// File: rtl/tdec_seq_track.sv
module tdec_seq_track #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             advance,
    input  logic [CNT_W-1:0] seq_len,
    input  logic [CNT_W-1:0] skip_raw,
    output logic [CNT_W-1:0] pos_q,
    output logic [CNT_W-1:0] cur_cnt
);
    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] base_pos;
    logic [CNT_W-1:0] clamped;
    logic             at_boundary;

    always_comb begin
        base_pos    = restart ? '0 : pos_q;
        at_boundary = (base_pos == '0);
        clamped     = (skip_raw > seq_len) ? seq_len : skip_raw;
        cur_cnt     = at_boundary ? clamped : act_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            act_q <= '0;
        end else if (advance) begin
            act_q <= cur_cnt;
            if (cur_cnt == '0) begin
                pos_q <= '0;
            end else if (base_pos == seq_len - 1'b1) begin
                pos_q <= '0;
            end else begin
                pos_q <= base_pos + 1'b1;
            end
        end else if (restart) begin
            pos_q <= '0;
        end
    end
endmodule

// File: rtl/tdec_accum.sv
module tdec_accum #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             advance,
    input  logic [CNT_W-1:0] seq_len,
    input  logic [CNT_W-1:0] cur_cnt,
    output logic             skip_now,
    output logic [CNT_W-1:0] acc_q
);
    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] len_ext;
    logic [CNT_W-1:0] base_acc;

    always_comb begin
        base_acc = restart ? '0 : acc_q;
        sum      = {1'b0, base_acc} + {1'b0, cur_cnt};
        len_ext  = {1'b0, seq_len};
        skip_now = (cur_cnt != '0) && (sum >= len_ext);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (advance) begin
            if (cur_cnt == '0) begin
                acc_q <= '0;
            end else if (skip_now) begin
                acc_q <= CNT_W'(sum - len_ext);
            end else begin
                acc_q <= CNT_W'(sum);
            end
        end else if (restart) begin
            acc_q <= '0;
        end
    end
endmodule

// File: rtl/tdec_top.sv
module tdec_top
    import tdec_pkg::*;
#(
    parameter int LEN_A = SEQ_LEN_SIXTY,
    parameter int LEN_B = SEQ_LEN_FIFTY,
    parameter int CNT_W = $clog2(((LEN_A > LEN_B) ? LEN_A : LEN_B) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             unit_start,
    input  logic             first_fld,
    input  logic             frame_mode,
    input  logic             std_sel,
    input  logic [CNT_W-1:0] skip_cnt,
    output logic             capture_en
);
    std_kind_e        std_q;
    std_kind_e        std_now;
    logic             restart;
    logic [CNT_W-1:0] seq_len;
    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] cur_cnt;
    logic [CNT_W-1:0] acc_q;
    logic             skip_now;
    logic             adv;
    unit_event_t      ev;

    always_comb begin
        std_now = std_kind_e'(std_sel);
        restart = (std_q != std_now);
        seq_len = CNT_W'(len_of(std_now, LEN_A, LEN_B));
        adv     = ev.advance;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            std_q <= std_now;
        end else begin
            std_q <= std_now;
        end
    end

    tdec_unit_gate gate_i (
        .unit_start (unit_start),
        .first_fld  (first_fld),
        .frame_mode (frame_mode),
        .ev         (ev)
    );

    tdec_seq_track #(.CNT_W(CNT_W)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .advance  (adv),
        .seq_len  (seq_len),
        .skip_raw (skip_cnt),
        .pos_q    (pos_q),
        .cur_cnt  (cur_cnt)
    );

    tdec_accum #(.CNT_W(CNT_W)) acc_i (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .advance  (adv),
        .seq_len  (seq_len),
        .cur_cnt  (cur_cnt),
        .skip_now (skip_now),
        .acc_q    (acc_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            capture_en <= 1'b1;
        end else if (adv) begin
            capture_en <= !skip_now;
        end
    end
endmodule

// File: rtl/tdec_checker.sv
module tdec_checker #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             unit_start,
    input logic             first_fld,
    input logic             frame_mode,
    input logic             capture_en,
    input logic             adv,
    input logic             restart,
    input logic [CNT_W-1:0] seq_len,
    input logic [CNT_W-1:0] cur_cnt,
    input logic [CNT_W-1:0] acc_q,
    input logic [CNT_W-1:0] pos_q
);
    a_r2_hold_between_units: assert property (@(posedge clk) disable iff (rst)
        !$past(unit_start) |-> $stable(capture_en));

    a_r8_second_field_repeats: assert property (@(posedge clk) disable iff (rst)
        $past(unit_start && frame_mode && !first_fld) |-> $stable(capture_en));

    a_r5_zero_captures: assert property (@(posedge clk) disable iff (rst)
        (adv && cur_cnt == '0) |=> capture_en);

    a_r6_full_skips: assert property (@(posedge clk) disable iff (rst)
        (adv && cur_cnt == seq_len) |=> !capture_en);

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
        !restart |-> (acc_q < seq_len));

    a_r11_pos_in_range: assert property (@(posedge clk) disable iff (rst)
        !restart |-> (pos_q < seq_len));
endmodule

bind tdec_top tdec_checker #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .unit_start (unit_start),
    .first_fld  (first_fld),
    .frame_mode (frame_mode),
    .capture_en (capture_en),
    .adv        (adv),
    .restart    (restart),
    .seq_len    (seq_len),
    .cur_cnt    (cur_cnt),
    .acc_q      (acc_q),
    .pos_q      (pos_q)
);

// File: tb/tdec_top_tb.sv
module tdec_top_tb_top;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             unit_start = 1'b0;
    logic             first_fld = 1'b0;
    logic             frame_mode = 1'b0;
    logic             std_sel = 1'b0;
    logic [CNT_W-1:0] skip_cnt = '0;
    logic             capture_en;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tdec_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .unit_start (unit_start),
        .first_fld  (first_fld),
        .frame_mode (frame_mode),
        .std_sel    (std_sel),
        .skip_cnt   (skip_cnt),
        .capture_en (capture_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit std, input int cnt, input bit fm);
        @(negedge clk);
        rst = 1'b1; std_sel = std; skip_cnt = CNT_W'(cnt); frame_mode = fm;
        unit_start = 1'b0; first_fld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // one unit pulse, returns capture_en sampled after the update edge
    task automatic unit(input bit first, output bit cap);
        unit_start = 1'b1; first_fld = first;
        @(negedge clk);
        unit_start = 1'b0; first_fld = 1'b0;
        cap = capture_en;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(1'b0, 30, 1'b0);
        chk(capture_en == 1'b1, "R1 reset capture", capture_en, 1);
    endtask

    task automatic t_half();
        bit c;
        bit ok = 1;
        do_reset(1'b0, 30, 1'b0);
        for (int i = 0; i < 8; i++) begin
            unit(i[0], c);
            if (c != (i % 2 == 0)) ok = 0;
        end
        chk(ok, "R4 half alternates", ok, 1);
        chk(ok, "R2 field mode ignores first_fld", ok, 1);
    endtask

    task automatic t_spread(input bit std, input int len, input int n);
        bit c;
        bit prev_skip = 0;
        int skips = 0;
        int run = 0;
        int max_run = 0;
        bit pair = 0;
        do_reset(std, n, 1'b0);
        for (int i = 0; i < len; i++) begin
            unit(1'b0, c);
            if (!c) begin
                skips++;
                if (prev_skip) pair = 1;
                run = 0;
            end else begin
                run++;
                if (run > max_run) max_run = run;
            end
            prev_skip = !c;
        end
        chk(skips == n, "R3 skips per sequence", skips, n);
        chk(!pair, "R4 no adjacent skips", pair, 0);
        chk(max_run <= (len - 1) / n, "R4 capture run bound", max_run, (len - 1) / n);
    endtask

    task automatic t_zero_full();
        bit c;
        int caps = 0;
        do_reset(1'b0, 0, 1'b0);
        for (int i = 0; i < 10; i++) begin unit(1'b0, c); caps += c; end
        chk(caps == 10, "R5 zero captures all", caps, 10);
        skip_cnt = 6'd30;
        @(negedge clk);
        unit(1'b0, c);
        chk(c == 1'b1, "R5 new count first unit", c, 1);
        unit(1'b0, c);
        chk(c == 1'b0, "R5 new count taken at once", c, 0);
        do_reset(1'b0, 60, 1'b0);
        caps = 0;
        for (int i = 0; i < 10; i++) begin unit(1'b0, c); caps += c; end
        chk(caps == 0, "R6 full count skips all", caps, 0);
        do_reset(1'b1, 63, 1'b0);
        caps = 0;
        for (int i = 0; i < 10; i++) begin unit(1'b0, c); caps += c; end
        chk(caps == 0, "R6 over-range clamps", caps, 0);
    endtask

    task automatic t_std();
        bit c;
        do_reset(1'b1, 50, 1'b0);
        unit(1'b0, c);
        chk(c == 1'b0, "R7 fifty-unit first skip", c, 0);
        do_reset(1'b0, 50, 1'b0);
        unit(1'b0, c);
        chk(c == 1'b1, "R7 sixty-unit first capture", c, 1);
        unit(1'b0, c);
        chk(c == 1'b0, "R7 sixty-unit second skip", c, 0);
    endtask

    task automatic t_frame();
        bit c1, c2;
        bit ok = 1;
        do_reset(1'b0, 30, 1'b1);
        for (int f = 0; f < 4; f++) begin
            unit(1'b1, c1);
            unit(1'b0, c2);
            if (c1 != (f % 2 == 0) || c2 != c1) ok = 0;
        end
        chk(ok, "R8 frame decision on both fields", ok, 1);
    endtask

    task automatic t_boundary();
        bit c;
        int skips = 0;
        do_reset(1'b0, 30, 1'b0);
        for (int i = 0; i < 10; i++) unit(1'b0, c);
        skip_cnt = 6'd60;
        @(negedge clk);
        unit(1'b0, c);
        chk(c == 1'b1, "R9 mid-sequence count ignored", c, 1);
        skips = 1 - c;
        for (int i = 12; i <= 60; i++) begin unit(1'b0, c); skips += (1 - c); end
        chk(skips == 25, "R9 old count finishes sequence", skips, 25);
        unit(1'b0, c);
        chk(c == 1'b0, "R9 new count at boundary", c, 0);
        unit(1'b0, c);
        chk(c == 1'b0, "R9 new count holds", c, 0);
    endtask

    task automatic t_std_change();
        bit c;
        do_reset(1'b0, 30, 1'b0);
        unit(1'b0, c);
        chk(c == 1'b1, "R10 before change", c, 1);
        std_sel = 1'b1; skip_cnt = 6'd25;
        @(negedge clk);
        unit(1'b0, c);
        chk(c == 1'b1, "R10 restart capture", c, 1);
        unit(1'b0, c);
        chk(c == 1'b0, "R10 restart then skip", c, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_half();
        t_spread(1'b0, 60, 7);
        t_spread(1'b1, 50, 13);
        t_spread(1'b0, 60, 20);
        t_zero_full();
        t_std();
        t_frame();
        t_boundary();
        t_std_change();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule